// File: doc/BRIEF.md
# ECC Diagnostic Error Logger

This block keeps a small set of diagnostic registers for an ECC decoder that sits beside it. Every rising edge of its dedicated syndrome clock it looks at the decoder's error and multiple-error flags. On the first error after a clear or reset, it freezes a snapshot of that error. The snapshot holds the stored check bits, the syndrome, the kind of error and the complete uncorrected 64-bit data word. Two other registers keep running: a saturating 4-bit count of error edges, and a syndrome register that reloads on every error edge.

Software or a test controller reads the registers through one 64-bit readback port, and a mode input picks what that port shows. In diagnostic mode the port shows the packed diagnostic fields. In error-data mode it shows the captured data word. The remaining modes drive zero. A clear input empties all the registers and arms first-error capture again. The ECC arithmetic is done outside this block.

Top module: `ecc_diag_log`

## Requirements
- R1: After a synchronous reset every register is zero, first-error capture is armed, and the readback is zero in every mode.
- R2: An error edge is any syndrome-clock edge with `err_i` or `merr_i` high and `clr_i` low. The check-bit, first syndrome, error-type and error-data registers load only on the first error edge since the last reset or clear. Later error edges leave them unchanged.
- R3: The running syndrome register loads `syn_i` on every error edge.
- R4: The error counter is 4 bits wide. It increments on each error edge and stays at 15 once it gets there.
- R5: With `mode_i` = 2'd1 (diagnostic), the readback places fields at these bits: check bits at [15:8], first syndrome at [23:16], error count at [27:24], error type at [29:28], running syndrome at [37:30]. Bits [7:0] and [63:38] are zero.
- R6: Error-type bit 28 holds `err_i` from the first error edge, and bit 29 holds `merr_i` from that edge.
- R7: An edge with `clr_i` high zeroes every register and arms first-error capture again. On that edge it overrides any error flag that is present.
- R8: With `mode_i` = 2'd2 (error data), the readback is the captured data word, or zero if nothing has been captured since the last clear or reset.
- R9: With `mode_i` = 2'd0 or 2'd3, the readback is zero.
- R10: An edge with no error flag and no clear leaves every register unchanged, whatever `syn_i`, `chk_i` and `data_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Syndrome clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| err_i | input | 1 | Error flag from the decoder |
| merr_i | input | 1 | Multiple-bit error flag from the decoder |
| syn_i | input | 8 | Syndrome from the decoder |
| chk_i | input | 8 | Check bits read from memory |
| data_i | input | 64 | Uncorrected memory data word |
| clr_i | input | 1 | Clear all registers and arm first-error capture again |
| mode_i | input | 2 | Readback select: 1 diagnostic, 2 error data, 0 and 3 zero |
| rdata_o | output | 64 | Readback word |

## Verification
The assertions assume that the decoder's flags, syndrome, check bits and data are stable around each syndrome-clock edge, and that clear is a synchronous level sampled on that edge. The bench changes every input one time unit after a rising edge and reads the readback on the falling edge. This keeps every input settled when the edge samples it. The random phase draws flags, clear and mode freely, including clear together with an error, so that the priority cases actually occur.

// File: rtl/ecc_diag_pkg.sv
package ecc_diag_pkg;

    localparam int DATA_W  = 64;
    localparam int SYN_W   = 8;
    localparam int CHK_W   = 8;
    localparam int CNT_W   = 4;
    localparam int TYPE_W  = 2;
    localparam int RD_W    = 64;
    localparam int MODE_W  = 2;

    // field placement inside the diagnostic readback word
    localparam int CHK_LSB   = 8;
    localparam int FIELDS_W  = CHK_W + SYN_W + CNT_W + TYPE_W + SYN_W;
    localparam int FIELDS_HI = CHK_LSB + FIELDS_W - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef enum logic [MODE_W-1:0] {
        RD_OFF   = 2'd0,
        RD_DIAG  = 2'd1,
        RD_EDATA = 2'd2,
        RD_OFF2  = 2'd3
    } rd_mode_e;

    // packed from msb to lsb so it drops straight onto readback bits
    typedef struct packed {
        logic [SYN_W-1:0]  syn_every;
        logic [TYPE_W-1:0] etype;
        logic [CNT_W-1:0]  count;
        logic [SYN_W-1:0]  syn_first;
        logic [CHK_W-1:0]  chk_first;
    } diag_fields_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/ecc_diag_first_cap.sv
module ecc_diag_first_cap
    import ecc_diag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 evt,
    input  logic                 err,
    input  logic                 merr,
    input  logic [CHK_W-1:0]     chk,
    input  logic [SYN_W-1:0]     syn,
    input  logic [DATA_W-1:0]    data,
    output logic                 seen_q,
    output logic [CHK_W-1:0]     chk_q,
    output logic [SYN_W-1:0]     syn_q,
    output logic [TYPE_W-1:0]    type_q,
    output logic [DATA_W-1:0]    data_q
);

    logic take;
    assign take = evt && !seen_q && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            seen_q <= 1'b0;
            chk_q  <= '0;
            syn_q  <= '0;
            type_q <= '0;
            data_q <= '0;
        end else if (take) begin
            seen_q <= 1'b1;
            chk_q  <= chk;
            syn_q  <= syn;
            type_q <= {merr, err};
            data_q <= data;
        end
    end

    // R2: once armed capture has fired, the snapshot is frozen until a clear
    a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !clr) |=> ($stable(data_q) && $stable(chk_q) && $stable(syn_q) && $stable(type_q)));

    // R2: the first error edge loads the presented data word
    a_r2_first_load: assert property (@(posedge clk) disable iff (rst)
        (!seen_q && evt && !clr) |=> (seen_q && data_q == $past(data)));

endmodule

// File: rtl/ecc_diag_running.sv
module ecc_diag_running
    import ecc_diag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              evt,
    input  logic [SYN_W-1:0]  syn,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [SYN_W-1:0]  syn_q
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            syn_q <= '0;
        end else if (evt) begin
            cnt_q <= sat_inc(cnt_q);
            syn_q <= syn;
        end
    end

    // R4: a full counter stays full until cleared
    a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));

    // R3: every error edge loads the running syndrome
    a_r3_track: assert property (@(posedge clk) disable iff (rst)
        (evt && !clr) |=> (syn_q == $past(syn)));

    // R7: clear empties the running registers on the next cycle
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0 && syn_q == '0));

    // R10: no error and no clear keeps the running registers
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        (!evt && !clr) |=> ($stable(cnt_q) && $stable(syn_q)));

endmodule

// File: rtl/ecc_diag_readout.sv
module ecc_diag_readout
    import ecc_diag_pkg::*;
(
    input  logic [MODE_W-1:0]  mode,
    input  diag_fields_t       fields,
    input  logic [DATA_W-1:0]  edata,
    output logic [RD_W-1:0]    rdata
);

    logic [RD_W-1:0] diag_word;

    always_comb begin
        diag_word = '0;
        diag_word[FIELDS_HI:CHK_LSB] = fields;
    end

    always_comb begin
        case (rd_mode_e'(mode))
            RD_DIAG:  rdata = diag_word;
            RD_EDATA: rdata = edata;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_diag_log.sv
module ecc_diag_log
    import ecc_diag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              err_i,
    input  logic              merr_i,
    input  logic [7:0]        syn_i,
    input  logic [7:0]        chk_i,
    input  logic [63:0]       data_i,
    input  logic              clr_i,
    input  logic [1:0]        mode_i,
    output logic [63:0]       rdata_o
);

    logic               evt;
    logic               seen;
    logic [CHK_W-1:0]   chk_first;
    logic [SYN_W-1:0]   syn_first;
    logic [TYPE_W-1:0]  etype;
    logic [DATA_W-1:0]  edata;
    logic [CNT_W-1:0]   count;
    logic [SYN_W-1:0]   syn_every;
    diag_fields_t       fields;

    assign evt = err_i || merr_i;

    ecc_diag_first_cap u_first (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_i),
        .evt    (evt),
        .err    (err_i),
        .merr   (merr_i),
        .chk    (chk_i),
        .syn    (syn_i),
        .data   (data_i),
        .seen_q (seen),
        .chk_q  (chk_first),
        .syn_q  (syn_first),
        .type_q (etype),
        .data_q (edata)
    );

    ecc_diag_running u_run (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_i),
        .evt   (evt),
        .syn   (syn_i),
        .cnt_q (count),
        .syn_q (syn_every)
    );

    always_comb begin
        fields.syn_every = syn_every;
        fields.etype     = etype;
        fields.count     = count;
        fields.syn_first = syn_first;
        fields.chk_first = chk_first;
    end

    ecc_diag_readout u_rd (
        .mode   (mode_i),
        .fields (fields),
        .edata  (edata),
        .rdata  (rdata_o)
    );

    // R5: in diagnostic mode the bits around the fields read zero
    a_r5_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1) |-> (rdata_o[63:38] == '0 && rdata_o[7:0] == '0));

    // R9: the quiet modes show nothing
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd0 || mode_i == 2'd3) |-> (rdata_o == '0));

    // R6: an error count without a captured type cannot happen
    a_r6_type_set: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |-> (etype != '0 && seen));

endmodule

// File: tb/sim_ecc_diag_log.sv
module sim_ecc_diag_log;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        err_i = 1'b0;
    logic        merr_i = 1'b0;
    logic [7:0]  syn_i = '0;
    logic [7:0]  chk_i = '0;
    logic [63:0] data_i = '0;
    logic        clr_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [63:0] rdata_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit model_on = 0;

    always #(PERIOD/2) clk = ~clk;

    ecc_diag_log u0 (
        .clk(clk), .rst(rst), .err_i(err_i), .merr_i(merr_i), .syn_i(syn_i),
        .chk_i(chk_i), .data_i(data_i), .clr_i(clr_i), .mode_i(mode_i),
        .rdata_o(rdata_o)
    );

    // behavioural reference
    bit          m_seen;
    int          m_cnt;
    logic [7:0]  m_chk, m_syn1, m_syn2;
    logic [1:0]  m_type;
    logic [63:0] m_data;

    always @(posedge clk) begin
        if (rst || clr_i) begin
            m_seen <= 0; m_cnt <= 0; m_chk <= 0; m_syn1 <= 0; m_syn2 <= 0;
            m_type <= 0; m_data <= 0;
        end else if (err_i || merr_i) begin
            if (!m_seen) begin
                m_seen <= 1; m_chk <= chk_i; m_syn1 <= syn_i;
                m_type <= {merr_i, err_i}; m_data <= data_i;
            end
            m_cnt  <= (m_cnt < 15) ? m_cnt + 1 : 15;
            m_syn2 <= syn_i;
        end
    end

    function automatic logic [63:0] pack(input logic [7:0] s2, input logic [1:0] t,
                                         input int c, input logic [7:0] s1,
                                         input logic [7:0] ck);
        logic [63:0] w;
        w = '0;
        w[37:30] = s2;
        w[29:28] = t;
        w[27:24] = 4'(c);
        w[23:16] = s1;
        w[15:8]  = ck;
        return w;
    endfunction

    function automatic logic [63:0] model_rd(input logic [1:0] md);
        case (md)
            2'd1: return pack(m_syn2, m_type, m_cnt, m_syn1, m_chk);
            2'd2: return m_data;
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (model_on && !done) begin
            case (mode_i)
                2'd1: check("R5 model", rdata_o, model_rd(mode_i));
                2'd2: check("R8 model", rdata_o, model_rd(mode_i));
                default: check("R9 model", rdata_o, model_rd(mode_i));
            endcase
        end
    end

    task automatic drive(input bit e, input bit m, input logic [7:0] s,
                         input logic [7:0] c, input logic [63:0] d, input bit cl,
                         input logic [1:0] md);
        err_i = e; merr_i = m; syn_i = s; chk_i = c; data_i = d; clr_i = cl; mode_i = md;
        @(posedge clk); #1;
    endtask

    task automatic look(input logic [1:0] md, input string tag, input logic [63:0] exp);
        err_i = 0; merr_i = 0; clr_i = 0; mode_i = md;
        syn_i = 8'hFF; chk_i = 8'hFF; data_i = '1;
        @(negedge clk);
        check(tag, rdata_o, exp);
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        model_on = 1;

        look(2'd1, "R1 reset diag", 64'd0);
        look(2'd2, "R1 reset edata", 64'd0);

        // first error, single-bit kind
        drive(1, 0, 8'h5A, 8'hC3, 64'h0123_4567_89AB_CDEF, 0, 2'd1);
        look(2'd1, "R5 R6 first error layout", pack(8'h5A, 2'b01, 1, 8'h5A, 8'hC3));
        look(2'd2, "R8 first error data", 64'h0123_4567_89AB_CDEF);

        // second error, multiple kind: snapshot frozen, running ones move
        drive(1, 1, 8'h33, 8'h11, 64'hDEAD_BEEF_0000_FFFF, 0, 2'd0);
        look(2'd1, "R2 R3 second error", pack(8'h33, 2'b01, 2, 8'h5A, 8'hC3));
        look(2'd2, "R2 data frozen", 64'h0123_4567_89AB_CDEF);

        // idle edges with noisy inputs change nothing
        drive(0, 0, 8'h99, 8'h77, 64'h1111_2222_3333_4444, 0, 2'd1);
        drive(0, 0, 8'h42, 8'h24, 64'h5555_6666_7777_8888, 0, 2'd2);
        look(2'd1, "R10 idle hold", pack(8'h33, 2'b01, 2, 8'h5A, 8'hC3));

        // saturation
        for (int i = 0; i < 20; i++)
            drive(1, 0, 8'(i + 8'h80), 8'h00, 64'(i), 0, 2'd1);
        look(2'd1, "R4 saturated", pack(8'h93, 2'b01, 15, 8'h5A, 8'hC3));
        drive(1, 0, 8'hA5, 8'h00, 64'd0, 0, 2'd1);
        look(2'd1, "R4 stays 15 R3 syn", pack(8'hA5, 2'b01, 15, 8'h5A, 8'hC3));

        // clear together with an error: clear wins
        drive(1, 1, 8'h01, 8'h02, 64'h0BAD, 1, 2'd1);
        look(2'd1, "R7 clear diag", 64'd0);
        look(2'd2, "R7 clear edata", 64'd0);

        // re-armed capture, multiple-error only
        drive(0, 1, 8'hE7, 8'h0F, 64'hCAFE_F00D_1234_5678, 0, 2'd2);
        look(2'd1, "R7 R6 rearm merr type", pack(8'hE7, 2'b10, 1, 8'hE7, 8'h0F));
        look(2'd2, "R7 rearm data", 64'hCAFE_F00D_1234_5678);
        look(2'd0, "R9 mode 0", 64'd0);
        look(2'd3, "R9 mode 3", 64'd0);

        // random phase checked by the reference on every cycle
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[0] & r[1], r[2] & r[3] & r[4], r[15:8], r[23:16],
                  {$urandom, $urandom}, (r[31:27] == 5'd0), r[26:25]);
        end

        // reset again mid-run
        rst = 1;
        @(posedge clk); #1;
        rst = 0;
        look(2'd1, "R1 second reset", 64'd0);

        finish_run();
    end

endmodule